// File: doc/BRIEF.md
# DMA Request Qualifier and Acknowledge Driver

This block sits between a single DMA channel engine and a bank of peripheral request lines. Configuration picks one of the request lines. The block then decides, by level or by edge and with either polarity enabled on its own, whether that line is asking for a transfer, and presents the answer to the channel as a single request signal.

As the channel moves each unit, it reports a read-done strobe, a write-done strobe and a last-unit flag. The block converts these into an acknowledge on the selected line and, for the final unit, a terminal-count indication on the same line. The acknowledge can be a single-clock pulse, can follow the request level, or can be suppressed. It is tied either to the read or to the write of the unit. Request lines are assumed to be synchronous to the block clock already.

Top module: `dma_req_handshake`

## Requirements
- R1: `cfgSel` (3 bits) chooses which bit of `reqLines`, `ackLines` and `tcLines` is in use. Every `ackLines` and `tcLines` bit other than bit `cfgSel` is always 0.
- R2: With `cfgLevel`=1, `chanReq` is combinational: (`cfgHiEn` AND selected line high) OR (`cfgLoEn` AND selected line low).
- R3: With `cfgLevel`=0, a rising edge of the selected line (when `cfgHiEn`=1) or a falling edge (when `cfgLoEn`=1) sets a pending request. An edge is a change between the value registered at the previous clock and the present value. `chanReq` shows this pending request from the next cycle until the clock edge at which the acknowledge phase strobe is seen.
- R4: In edge mode, an edge that arrives while a request is pending is ignored, including an edge in the same cycle as the clearing phase strobe.
- R5: With both `cfgHiEn` and `cfgLoEn` at 0, no request is recognised in either mode.
- R6: The acknowledge phase strobe is `rdDone` when `cfgDstSide`=0 and `wrDone` when `cfgDstSide`=1. The other strobe has no effect on the acknowledge, on the terminal count or on the pending request.
- R7: `cfgAckMode`=00 (pulse): the selected acknowledge is high for exactly the one cycle that follows a phase strobe.
- R8: `cfgAckMode`=01 (level): the acknowledge rises in the cycle after a phase strobe. It stays high while the selected request remains recognised as active (R2 expression), and falls in the cycle after the request stops being recognised.
- R9: `cfgAckMode`=10 or 11 (masked): no acknowledge line ever goes high.
- R10: A phase strobe with `lastUnit`=1 drives the selected terminal-count line high for exactly the following cycle, which is the same cycle as the pulse-mode acknowledge.
- R11: With `cfgTcMask`=1, no terminal-count line goes high.
- R12: While `rstN` is low, and in the first cycle after it, `ackLines`, `tcLines` and the pending request are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSel | input | 3 | Selected line index |
| cfgLevel | input | 1 | 1 = level detection, 0 = edge detection |
| cfgHiEn | input | 1 | Recognise high level / rising edge |
| cfgLoEn | input | 1 | Recognise low level / falling edge |
| cfgAckMode | input | 2 | 00 pulse, 01 level-follow, 1x masked |
| cfgDstSide | input | 1 | 0 = acknowledge on read, 1 = acknowledge on write |
| cfgTcMask | input | 1 | 1 = suppress terminal-count output |
| reqLines | input | 8 | Peripheral request lines |
| rdDone | input | 1 | Channel finished the read of a unit |
| wrDone | input | 1 | Channel finished the write of a unit |
| lastUnit | input | 1 | Current unit is the final one |
| chanReq | output | 1 | Qualified request to the channel |
| ackLines | output | 8 | Acknowledge lines, one per peripheral |
| tcLines | output | 8 | Terminal-count lines, one per peripheral |

## Verification
Random configurations are combined with request lines that toggle slowly, so that both level and edge qualification see stable stretches and isolated transitions. Sparse read and write strobes on both sides separate the source-side timing from the destination-side timing. Directed sequences add extra edges while a request is pending, strobes on the wrong side, both polarity enables cleared, and masking of acknowledge and terminal count. These show whether a stray input leaks into the outputs. Line selection is changed between runs, so an acknowledge appearing on any unselected bit marks a decode fault.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  typedef enum logic [1:0] {
    ACK_PULSE  = 2'b00,
    ACK_LEVEL  = 2'b01,
    ACK_MASK_A = 2'b10,
    ACK_MASK_B = 2'b11
  } ackMode_e;

  typedef struct packed {
    logic unitPhase;
    logic lastPhase;
    logic reqActive;
  } hsStrobe_t;
endpackage

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
  import dma_hs_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int SEL_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SEL_W-1:0]     cfgSel,
  input  logic                 cfgLevel,
  input  logic                 cfgHiEn,
  input  logic                 cfgLoEn,
  input  logic                 cfgDstSide,
  input  logic [NUM_LINES-1:0] reqLines,
  input  logic                 rdDone,
  input  logic                 wrDone,
  input  logic                 lastUnit,
  output logic                 chanReq,
  output hsStrobe_t            strobes
);
  logic [NUM_LINES-1:0] prevLines;
  logic selNow, selPrev, edgeHit, reqActive, unitPhase, pending;

  assign selNow    = reqLines[cfgSel];
  assign selPrev   = prevLines[cfgSel];
  assign reqActive = (cfgHiEn & selNow) | (cfgLoEn & ~selNow);
  assign edgeHit   = (cfgHiEn & selNow & ~selPrev) | (cfgLoEn & ~selNow & selPrev);
  assign unitPhase = cfgDstSide ? wrDone : rdDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLines <= '0;
      pending   <= 1'b0;
    end else begin
      prevLines <= reqLines;
      if (cfgLevel)     pending <= 1'b0;
      else if (pending) pending <= ~unitPhase;
      else              pending <= edgeHit;
    end
  end

  assign chanReq = cfgLevel ? reqActive : pending;

  always_comb begin
    strobes.unitPhase = unitPhase;
    strobes.lastPhase = unitPhase & lastUnit;
    strobes.reqActive = reqActive;
  end

  // R3: a pending edge request survives until its acknowledge phase
  a_r3_pending_held: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !unitPhase && !cfgLevel) |=> (pending || $past(cfgLevel) || cfgLevel));

  // R4: a pending request is cleared by the phase strobe and not re-armed in that cycle
  a_r4_clear_no_rearm: assert property (@(posedge clk) disable iff (!rstN)
    (pending && unitPhase && !cfgLevel) |=> !pending);

  // R5: nothing recognised with both enables clear
  always_comb begin
    if (rstN && cfgLevel && !cfgHiEn && !cfgLoEn)
      a_r5_no_enable: assert (!chanReq);
  end
endmodule

// File: rtl/dma_hs_path.sv
module dma_hs_path
  import dma_hs_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int SEL_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SEL_W-1:0]     cfgSel,
  input  logic [1:0]           cfgAckMode,
  input  logic                 cfgTcMask,
  input  hsStrobe_t            strobes,
  output logic [NUM_LINES-1:0] ackLines,
  output logic [NUM_LINES-1:0] tcLines
);
  ackMode_e ackMode;
  logic ackState, tcState;

  assign ackMode = ackMode_e'(cfgAckMode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackState <= 1'b0;
      tcState  <= 1'b0;
    end else begin
      unique case (ackMode)
        ACK_PULSE: ackState <= strobes.unitPhase;
        ACK_LEVEL: ackState <= (strobes.unitPhase | ackState) & strobes.reqActive;
        default:   ackState <= 1'b0;
      endcase
      tcState <= strobes.lastPhase & ~cfgTcMask;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign ackLines[i] = ackState & (cfgSel == SEL_W'(i));
    assign tcLines[i]  = tcState  & (cfgSel == SEL_W'(i));
  end

  // R7: pulse mode acknowledges in the cycle after a phase strobe
  a_r7_pulse_follows: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.unitPhase && cfgAckMode == 2'b00) |=> (ackLines != '0));

  // R9: masked mode never acknowledges
  a_r9_masked: assert property (@(posedge clk) disable iff (!rstN)
    cfgAckMode[1] |=> (ackLines == '0));

  // R11: terminal-count mask
  a_r11_tc_masked: assert property (@(posedge clk) disable iff (!rstN)
    cfgTcMask |=> (tcLines == '0));

  // R10: terminal count coincides with the pulse-mode acknowledge
  a_r10_tc_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lastPhase && cfgAckMode == 2'b00) |=> ($stable(cfgSel) ? (tcLines == ackLines || tcLines == '0) : 1'b1));

  // R1: at most one line driven
  a_r1_one_line: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackLines) && $onehot0(tcLines));
endmodule

// File: rtl/dma_req_handshake.sv
module dma_req_handshake
  import dma_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cfgSel,
  input  logic       cfgLevel,
  input  logic       cfgHiEn,
  input  logic       cfgLoEn,
  input  logic [1:0] cfgAckMode,
  input  logic       cfgDstSide,
  input  logic       cfgTcMask,
  input  logic [7:0] reqLines,
  input  logic       rdDone,
  input  logic       wrDone,
  input  logic       lastUnit,
  output logic       chanReq,
  output logic [7:0] ackLines,
  output logic [7:0] tcLines
);
  localparam int NUM_LINES = 8;
  hsStrobe_t strobes;

  dma_hs_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .cfgLevel(cfgLevel),
    .cfgHiEn(cfgHiEn), .cfgLoEn(cfgLoEn), .cfgDstSide(cfgDstSide),
    .reqLines(reqLines), .rdDone(rdDone), .wrDone(wrDone),
    .lastUnit(lastUnit), .chanReq(chanReq), .strobes(strobes)
  );

  dma_hs_path #(.NUM_LINES(NUM_LINES)) u_path (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .cfgAckMode(cfgAckMode),
    .cfgTcMask(cfgTcMask), .strobes(strobes),
    .ackLines(ackLines), .tcLines(tcLines)
  );
endmodule

// File: tb/dma_req_handshake_tb.sv
module dma_req_handshake_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN;
  logic [2:0] cfgSel;
  logic cfgLevel, cfgHiEn, cfgLoEn, cfgDstSide, cfgTcMask;
  logic [1:0] cfgAckMode;
  logic [7:0] reqLines;
  logic rdDone, wrDone, lastUnit;
  logic chanReq;
  logic [7:0] ackLines, tcLines;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [7:0] mPrev;
  logic mPend, mAck, mTc;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_handshake u_dut (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .cfgLevel(cfgLevel),
    .cfgHiEn(cfgHiEn), .cfgLoEn(cfgLoEn), .cfgAckMode(cfgAckMode),
    .cfgDstSide(cfgDstSide), .cfgTcMask(cfgTcMask), .reqLines(reqLines),
    .rdDone(rdDone), .wrDone(wrDone), .lastUnit(lastUnit),
    .chanReq(chanReq), .ackLines(ackLines), .tcLines(tcLines)
  );

  function automatic logic expActive();
    logic s = reqLines[cfgSel];
    return (cfgHiEn & s) | (cfgLoEn & ~s);
  endfunction

  function automatic logic expReq();
    return cfgLevel ? expActive() : mPend;
  endfunction

  function automatic logic [7:0] onLine(input logic v);
    return v ? (8'h01 << cfgSel) : 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare all outputs, then advance the reference at the clock edge
  task automatic step(input string tag);
    string tReq, tAck, tTc;
    logic [7:0] eAck, eTc;
    logic s, sp, edgeHit, phase;
    #1;
    eAck = onLine(mAck);
    eTc  = onLine(mTc);
    tReq = (tag != "") ? tag : (cfgLevel ? ((!cfgHiEn && !cfgLoEn) ? "R5" : "R2") : "R3");
    tAck = (tag != "") ? tag : ((ackLines & ~onLine(1'b1)) != 0 ? "R1" :
            (cfgAckMode == 2'b00 ? "R7" : (cfgAckMode == 2'b01 ? "R8" : "R9")));
    tTc  = (tag != "") ? tag : ((tcLines & ~onLine(1'b1)) != 0 ? "R1" : (cfgTcMask ? "R11" : "R10"));
    check(tReq, {7'b0, chanReq}, {7'b0, expReq()});
    check(tAck, ackLines, eAck);
    check(tTc, tcLines, eTc);
    @(posedge clk);
    s = reqLines[cfgSel];
    sp = mPrev[cfgSel];
    edgeHit = (cfgHiEn & s & ~sp) | (cfgLoEn & ~s & sp);
    phase = cfgDstSide ? wrDone : rdDone;
    if (!rstN) begin
      mPrev = '0; mPend = 0; mAck = 0; mTc = 0;
    end else begin
      if (cfgLevel) mPend = 0;
      else if (mPend) mPend = ~phase;
      else mPend = edgeHit;
      case (cfgAckMode)
        2'b00:   mAck = phase;
        2'b01:   mAck = (phase | mAck) & expActive();
        default: mAck = 0;
      endcase
      mTc = phase & lastUnit & ~cfgTcMask;
      mPrev = reqLines;
    end
    @(negedge clk);
  endtask

  task automatic setCfg(input logic [2:0] sel, input logic lvl, input logic hi, input logic lo,
                        input logic [1:0] am, input logic dst, input logic tcm);
    cfgSel = sel; cfgLevel = lvl; cfgHiEn = hi; cfgLoEn = lo;
    cfgAckMode = am; cfgDstSide = dst; cfgTcMask = tcm;
  endtask

  task automatic idleStrobes();
    rdDone = 0; wrDone = 0; lastUnit = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rstN = 0; reqLines = 0; idleStrobes();
    setCfg(3'd2, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    mPrev = 0; mPend = 0; mAck = 0; mTc = 0;
    @(negedge clk);
    rdDone = 1; lastUnit = 1;
    step("R12"); step("R12");
    rstN = 1; idleStrobes();
    step("R12");

    // R3/R4: edge pending, extra edges ignored, cleared by read strobe
    reqLines[2] = 1; step("R3");
    step("R3");
    reqLines[2] = 0; step("R4");
    reqLines[2] = 1; step("R4");
    // R6: write strobe on the wrong side has no effect
    wrDone = 1; lastUnit = 1; step("R6");
    idleStrobes(); step("R6");
    // clearing read strobe together with a new edge: edge ignored
    reqLines[2] = 0; setCfg(3'd2, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0);
    rdDone = 1; lastUnit = 1; step("R4");
    idleStrobes(); step("R10"); step("R4");

    // R5: no enables, both modes
    setCfg(3'd5, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0);
    reqLines = 8'hFF; step("R5");
    reqLines = 8'h00; step("R5");
    setCfg(3'd5, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0);
    reqLines = 8'hFF; step("R5"); step("R5");

    // R8: level-follow on destination side, active low
    setCfg(3'd6, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0);
    reqLines = 8'h00; step("R8");
    wrDone = 1; step("R8");
    idleStrobes(); step("R8"); step("R8");
    reqLines = 8'h40; step("R8"); step("R8");

    // R9/R11: masked acknowledge and terminal count
    setCfg(3'd1, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b1);
    reqLines = 8'h02; rdDone = 1; lastUnit = 1; step("R9");
    step("R11"); idleStrobes(); step("R9");

    // random phase
    for (int blk = 0; blk < 60; blk++) begin
      setCfg(3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom), 1'($urandom),
             2'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
      for (int c = 0; c < 40; c++) begin
        if ($urandom_range(0, 5) == 0) reqLines = reqLines ^ (8'h01 << $urandom_range(0, 7));
        rdDone   = ($urandom_range(0, 4) == 0);
        wrDone   = ($urandom_range(0, 4) == 0);
        lastUnit = ($urandom_range(0, 2) == 0);
        step("");
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule